// File: doc/BRIEF.md
# Fetch-Group Last-Outcome Predictor

This block gives the fetch stage a one-bit direction guess for each aligned group of four instructions. A flat array of bits holds them, one bit per group, and it is addressed with the same index bits the instruction cache uses for its lines. Whenever the fetch stage presents a valid address, the block looks up that group's bit in the same cycle. When the bit is one, it raises a redirect and passes on the target address that the caller supplies.

When a branch later resolves, the execute side reports the branch address and whether it was taken. The block then overwrites the bit of the enclosing group with that outcome. Nothing is kept per branch and there are no tags. All branches that fall in one group therefore share one bit, and the most recent resolution replaces whatever an earlier one wrote. A group with no branch in it keeps a bit that is never set. Target computation, tag matching and the cache data array belong to the surrounding logic.

Top module: `fetch_group_predictor`

## Requirements
- R1: A synchronous reset with `rst_n` low clears every history bit, so after reset no group causes a redirect.
- R2: `redir_valid` is high in the same cycle as `fetch_valid`, with no register in the path, exactly when the history bit of the fetched group is 1.
- R3: `redir_addr` equals `fetch_target` while `redir_valid` is high and is all zeros otherwise.
- R4: An update with `upd_taken` = 1 sets the group's bit at the clock edge, so a fetch of that group in the following cycle redirects.
- R5: An update with `upd_taken` = 0 clears the group's bit at the clock edge.
- R6: The group index is address bits [9:4] with the default 64 groups. Addresses that differ only in bits [3:0] share one bit. Addresses that differ only above bit 9 also share one bit.
- R7: Updates from different branches in one group overwrite each other; the last one written decides the next prediction.
- R8: When a fetch and an update name the same group in one cycle, the fetch sees the bit as it was before that update.
- R9: With `fetch_valid` low, `redir_valid` stays low even when the addressed bit is 1.
- R10: An update changes only the bit of its own group; all other groups keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_addr | input | ADDR_W | Byte address of the fetched group |
| fetch_target | input | ADDR_W | Address to redirect to, supplied by the caller |
| redir_valid | output | 1 | Redirect the fetch stream this cycle |
| redir_addr | output | ADDR_W | Redirect address; zero when no redirect is made |
| upd_valid | input | 1 | A branch resolved this cycle |
| upd_addr | input | ADDR_W | Byte address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch (1 = taken) |

## Verification
A prediction is due in the same cycle as its fetch. An update becomes visible exactly one clock edge after it is presented. The bench drives each cycle's inputs just after the falling edge and samples `redir_valid` and `redir_addr` one nanosecond later, which is before the next rising edge. As a result, an update in a vector row is still unseen by that row's own check, which tests R8. The row after it does see the update. Directed tests then sweep every group around a mid-run reset to cover R1 and R10 at the index boundaries.

// File: rtl/fgp_pkg.sv
// Package: shared address-split constants for the fetch-group predictor.
// Assumes 4-byte instructions packed four to a fetch group.
package fgp_pkg;
    localparam int INSTR_OFF_BITS  = 2;  // byte offset inside one instruction
    localparam int GROUP_SLOT_BITS = 2;  // instruction slot inside a group
    localparam int IDX_LSB         = INSTR_OFF_BITS + GROUP_SLOT_BITS;
endpackage

// File: rtl/fgp_index.sv
// Module: fgp_index
// Extracts the group index from a byte address. The index is the IDX_W bits
// just above the in-group offset, which matches the cache line index.
// Assumes ADDR_W > IDX_LSB + IDX_W.
module fgp_index
    import fgp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

    // Slice the group index out of the address.
    always_comb begin
        idx = addr[IDX_MSB:IDX_LSB];
    end
endmodule

// File: rtl/fgp_hist_bits.sv
// Module: fgp_hist_bits
// One history bit per fetch group. The read is combinational from the current
// contents, and the write lands at the clock edge, so a read and a write to
// the same entry in one cycle return the old value. Reset is synchronous and
// clears every entry.
module fgp_hist_bits #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] hist_q;

    // Clear on reset; otherwise overwrite the addressed entry with the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (wr_en) begin
            hist_q[wr_idx] <= wr_bit;
        end
    end

    // Read the addressed entry as it stands before this cycle's write.
    always_comb begin
        rd_bit = hist_q[rd_idx];
    end

    // R1: the cycle after reset, every entry is clear.
    p_reset_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (hist_q == '0));

    // R4 / R5: a write lands with the value written.
    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en)) |-> (hist_q[$past(wr_idx)] == $past(wr_bit)));

    // R10: without a write, no entry changes.
    p_hold_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en)) |-> $stable(hist_q));
endmodule

// File: rtl/fetch_group_predictor.sv
// Module: fetch_group_predictor
// Predicts that each four-instruction fetch group behaves as its last resolved
// branch did. It has no tags, so groups that alias on the index share a bit.
// Assumes the caller supplies the redirect target and the branch outcome.
module fetch_group_predictor
    import fgp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ADDR_W-1:0] fetch_target,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_addr,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken
);
    logic [IDX_W-1:0] fetch_idx;
    logic [IDX_W-1:0] upd_idx;
    logic             hist_bit;

    fgp_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_fetch_index (
        .addr (fetch_addr),
        .idx  (fetch_idx)
    );

    fgp_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_upd_index (
        .addr (upd_addr),
        .idx  (upd_idx)
    );

    fgp_hist_bits #(.IDX_W(IDX_W)) i_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (fetch_idx),
        .rd_bit (hist_bit),
        .wr_en  (upd_valid),
        .wr_idx (upd_idx),
        .wr_bit (upd_taken)
    );

    // Raise a redirect for a valid fetch whose group bit is set; gate the target.
    always_comb begin
        redir_valid = fetch_valid & hist_bit;
        redir_addr  = redir_valid ? fetch_target : '0;
    end

    // R4 / R5 / R7: the cycle after an update, a fetch of that group follows its outcome.
    p_follow_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd_valid) && fetch_valid && (fetch_idx == $past(upd_idx)))
        |-> (redir_valid == $past(upd_taken)));
endmodule

// File: tb/test_fetch_group_predictor.sv
module test_fetch_group_predictor;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 6;
    localparam int GROUPS = 1 << IDX_W;

    typedef struct packed {
        logic        uv;
        logic [31:0] ua;
        logic        ut;
        logic        fv;
        logic [31:0] fa;
        logic        exp;
    } vec_t;

    // Group index = addr[9:4]. 0x100 and 0x500 -> group 16, 0x110 -> 17, 0x200 -> 32, 0x3F0 -> 63.
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0,   1'b0, 1'b1, 32'h100, 1'b0},  // R1 clear after reset
        '{1'b1, 32'h104, 1'b1, 1'b1, 32'h100, 1'b0},  // R8 same-cycle update unseen
        '{1'b0, 32'h0,   1'b0, 1'b1, 32'h10C, 1'b1},  // R4 / R6 shared in group
        '{1'b0, 32'h0,   1'b0, 1'b1, 32'h110, 1'b0},  // R10 neighbour untouched
        '{1'b0, 32'h0,   1'b0, 1'b1, 32'h500, 1'b1},  // R6 alias above bit 9
        '{1'b1, 32'h108, 1'b0, 1'b1, 32'h100, 1'b1},  // R8 old value seen
        '{1'b0, 32'h0,   1'b0, 1'b1, 32'h100, 1'b0},  // R5 / R7 last branch wins
        '{1'b1, 32'h200, 1'b1, 1'b0, 32'h200, 1'b0},  // R9 no fetch
        '{1'b0, 32'h0,   1'b0, 1'b0, 32'h200, 1'b0},  // R9 bit set but no fetch
        '{1'b1, 32'h204, 1'b1, 1'b1, 32'h20C, 1'b1},  // R2 / R3 redirect
        '{1'b1, 32'h208, 1'b0, 1'b1, 32'h3F0, 1'b0},  // R10 top group clear
        '{1'b0, 32'h0,   1'b0, 1'b1, 32'h200, 1'b0}   // R7 later not-taken wins
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fetch_valid = 1'b0;
    logic [ADDR_W-1:0] fetch_addr = '0;
    logic [ADDR_W-1:0] fetch_target = '0;
    logic              redir_valid;
    logic [ADDR_W-1:0] redir_addr;
    logic              upd_valid = 1'b0;
    logic [ADDR_W-1:0] upd_addr = '0;
    logic              upd_taken = 1'b0;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    fetch_group_predictor #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_fetch_group_predictor (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_valid  (fetch_valid),
        .fetch_addr   (fetch_addr),
        .fetch_target (fetch_target),
        .redir_valid  (redir_valid),
        .redir_addr   (redir_addr),
        .upd_valid    (upd_valid),
        .upd_addr     (upd_addr),
        .upd_taken    (upd_taken)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle after the falling edge, then sample before the rising edge.
    task automatic drive(input logic uv, input logic [31:0] ua, input logic ut,
                         input logic fv, input logic [31:0] fa);
        @(negedge clk);
        upd_valid    = uv;
        upd_addr     = ua;
        upd_taken    = ut;
        fetch_valid  = fv;
        fetch_addr   = fa;
        fetch_target = fa ^ 32'h8000_1000;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].uv, VECS[i].ua, VECS[i].ut, VECS[i].fv, VECS[i].fa);
            check($sformatf("R2 row %0d redir_valid", i), {31'b0, redir_valid}, {31'b0, VECS[i].exp});
            check($sformatf("R3 row %0d redir_addr", i), redir_addr,
                  VECS[i].exp ? (VECS[i].fa ^ 32'h8000_1000) : 32'h0);
        end
        // R10: set every group one at a time; the next group must still be clear.
        for (int g = 0; g < GROUPS; g++) begin
            drive(1'b1, 32'(g) << 4, 1'b1, 1'b1, 32'((g + 1) % GROUPS) << 4);
            check($sformatf("R10 group %0d before set", (g + 1) % GROUPS), {31'b0, redir_valid},
                  (g == GROUPS - 1) ? 32'h1 : 32'h0);
        end
        drive(1'b0, 32'h0, 1'b0, 1'b1, 32'h3F0);
        check("R4 top group set", {31'b0, redir_valid}, 32'h1);
        // R1: a mid-run reset clears all groups.
        @(negedge clk);
        rst_n = 1'b0;
        upd_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int g = 0; g < GROUPS; g++) begin
            drive(1'b0, 32'h0, 1'b0, 1'b1, 32'(g) << 4);
            check($sformatf("R1 group %0d after reset", g), {31'b0, redir_valid}, 32'h0);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule